// File: doc/BRIEF.md
# Cable Power-Feed Detection Controller

This block sits on the supply side of a high-power cable feed. It decides whether the main supply may be switched onto the line. First it applies a low sense voltage and reads a comparator flag that reports whether the line resistance lies inside the accepted window (3.2 kilohm or less). Optionally it also requires proof that both pair groups are connected. The far end takes no part in any exchange, so the decision rests only on the measured load.

When the signature is good, the controller closes the main switch for a fixed probe window of 876 ms by default. At the end of that window it checks that the load is still drawing current. If it is, the feed stays on until the current drops below a hold level or an overcurrent occurs. Every failure removes power and waits through a 450 ms back-off before a new attempt. All windows are counted on a 1 ms tick input. Each window length is a parameter.

Top module: `pwr_feed_detect`

## Requirements
- R1: While reset is held and in the first cycle after it, `status` is 0, `sense_en` is 0 and `main_en` is 0.
- R2: In IDLE (status 0), the controller waits BACKOFF_MS ticks of `ms_tick` and then enters DETECT. A cycle with `ms_tick` low does not advance the back-off, sense or probe timing.
- R3: In DETECT (status 1), `sense_en` is 1 for SENSE_MS ticks. On the last tick the controller goes to PROBE_ON if the signature is valid and to IDLE if it is not. An invalid signature never leads to `main_en` being 1.
- R4: The signature is valid when `sig_in_range` is 1 and, if `all_pairs_req` is 1, `pairs_cont` is also 1. When `all_pairs_req` is 0, `pairs_cont` has no effect.
- R5: In PROBE_ON (status 2), `main_en` is 1 for PROBE_MS ticks. On the last tick the controller goes to ON if `load_present` is 1 and to IDLE if it is not. The value of `load_present` before that last tick has no effect.
- R6: If `over_current` is 1 in any cycle of PROBE_ON or ON, the next cycle shows status 0 with `main_en` 0. This takes priority over a probe window that completes in the same cycle.
- R7: ON (status 3) persists while `hold_present` is 1 and `over_current` is 0. If `hold_present` is 0 in ON, the next cycle shows IDLE.
- R8: `sense_en` and `main_en` are never 1 in the same cycle.
- R9: The status encoding is IDLE=0, DETECT=1, PROBE_ON=2, ON=3. `sense_en` is 1 exactly in DETECT. `main_en` is 1 exactly in PROBE_ON and ON.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| sig_in_range | input | 1 | Line resistance is inside the signature window |
| pairs_cont | input | 1 | Continuity seen between the two pair groups |
| all_pairs_req | input | 1 | Also require pair-group continuity for a valid signature |
| load_present | input | 1 | Load current is above the probe acceptance level |
| hold_present | input | 1 | Load current is above the hold level |
| over_current | input | 1 | Load current is above the trip level |
| sense_en | output | 1 | Apply the low sense voltage |
| main_en | output | 1 | Close the main power switch |
| status | output | 2 | Controller state code |

## Verification
Two events can fall in the same cycle: the tick that ends the probe window with `load_present` high, and an overcurrent trip. The bench watches its own model and waits until the model sits on the last count of the probe window. It then forces `ms_tick` and `over_current` high together, with `load_present` also high. The result must be IDLE with the switch open, not ON. A cycle-accurate model also follows every cycle, including runs where ticks are withheld at random and `load_present` changes mid-window.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DETECT = 2'd1,
        ST_PROBE  = 2'd2,
        ST_ON     = 2'd3
    } pfd_state_e;

endpackage

// File: rtl/pfd_window_timer.sv
module pfd_window_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             done,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t cur_q, nxt_d;

    // Expiry depends only on the stored count, never on restart.
    assign done  = tick && (cur_q.cnt == (limit - CNT_W'(1)));
    assign count = cur_q.cnt;

    always_comb begin
        nxt_d = cur_q;
        if (restart) begin
            nxt_d.cnt = '0;
        end else if (done) begin
            nxt_d.cnt = '0;
        end else if (tick) begin
            nxt_d.cnt = cur_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    // R2: the count never reaches the active window limit.
    p_cnt_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt < limit);

    // R2: a plain tick advances the count by exactly one.
    p_tick_advances_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && !done) |=> (cur_q.cnt == $past(cur_q.cnt) + CNT_W'(1)));

    // R2: with no tick and no restart the count holds.
    p_no_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(cur_q.cnt));

endmodule

// File: rtl/pfd_sig_judge.sv
module pfd_sig_judge (
    input  logic sig_in_range,
    input  logic pairs_cont,
    input  logic all_pairs_req,
    output logic sig_valid
);

    logic pair_gate;

    always_comb begin
        pair_gate = 1'b1;
        if (all_pairs_req) begin
            pair_gate = pairs_cont;
        end
        sig_valid = sig_in_range && pair_gate;
    end

    // R4: with the pair check requested, missing continuity blocks the signature.
    always_comb begin
        if (all_pairs_req && !pairs_cont) begin
            a_pairs_block_r4: assert (!sig_valid);
        end
    end

endmodule

// File: rtl/pfd_load_guard.sv
module pfd_load_guard
    import pfd_pkg::*;
(
    input  pfd_state_e state,
    input  logic       over_current,
    input  logic       hold_present,
    output logic       trip,
    output logic       sag
);

    logic powered;

    always_comb begin
        powered = (state == ST_PROBE) || (state == ST_ON);
        trip    = powered && over_current;
        sag     = (state == ST_ON) && !hold_present;
    end

    // R6: a trip is only ever reported while the switch is meant to be closed.
    always_comb begin
        if (trip) begin
            a_trip_when_powered_r6: assert (powered);
        end
    end

endmodule

// File: rtl/pwr_feed_detect.sv
module pwr_feed_detect
    import pfd_pkg::*;
#(
    parameter int SENSE_MS   = 5,
    parameter int PROBE_MS   = 876,
    parameter int BACKOFF_MS = 450
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       sig_in_range,
    input  logic       pairs_cont,
    input  logic       all_pairs_req,
    input  logic       load_present,
    input  logic       hold_present,
    input  logic       over_current,
    output logic       sense_en,
    output logic       main_en,
    output logic [1:0] status
);

    localparam int MAX_A  = (PROBE_MS > BACKOFF_MS) ? PROBE_MS : BACKOFF_MS;
    localparam int MAX_MS = (MAX_A > SENSE_MS) ? MAX_A : SENSE_MS;
    localparam int CNT_W  = $clog2(MAX_MS + 1);

    localparam logic [CNT_W-1:0] LIM_IDLE   = CNT_W'(BACKOFF_MS);
    localparam logic [CNT_W-1:0] LIM_DETECT = CNT_W'(SENSE_MS);
    localparam logic [CNT_W-1:0] LIM_PROBE  = CNT_W'(PROBE_MS);
    localparam logic [CNT_W-1:0] LIM_ON     = CNT_W'(1);

    typedef struct packed {
        pfd_state_e state;
        logic       sense;
        logic       main;
    } ctl_t;

    ctl_t cur_q, nxt_d;

    logic             win_done;
    logic             win_restart;
    logic [CNT_W-1:0] win_limit;
    logic [CNT_W-1:0] win_count;
    logic             sig_valid;
    logic             trip;
    logic             sag;

    initial begin
        if (SENSE_MS < 1 || PROBE_MS < 1 || BACKOFF_MS < 1) begin
            $error("window lengths must be at least one tick");
        end
    end

    always_comb begin
        unique case (cur_q.state)
            ST_IDLE:   win_limit = LIM_IDLE;
            ST_DETECT: win_limit = LIM_DETECT;
            ST_PROBE:  win_limit = LIM_PROBE;
            default:   win_limit = LIM_ON;
        endcase
    end

    pfd_window_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (win_restart),
        .tick    (ms_tick),
        .limit   (win_limit),
        .done    (win_done),
        .count   (win_count)
    );

    pfd_sig_judge u_judge (
        .sig_in_range  (sig_in_range),
        .pairs_cont    (pairs_cont),
        .all_pairs_req (all_pairs_req),
        .sig_valid     (sig_valid)
    );

    pfd_load_guard u_guard (
        .state        (cur_q.state),
        .over_current (over_current),
        .hold_present (hold_present),
        .trip         (trip),
        .sag          (sag)
    );

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (win_done) begin
                    nxt_d.state = ST_DETECT;
                end
            end
            ST_DETECT: begin
                if (win_done) begin
                    nxt_d.state = sig_valid ? ST_PROBE : ST_IDLE;
                end
            end
            ST_PROBE: begin
                if (trip) begin
                    nxt_d.state = ST_IDLE;
                end else if (win_done) begin
                    nxt_d.state = load_present ? ST_ON : ST_IDLE;
                end
            end
            default: begin
                if (trip || sag) begin
                    nxt_d.state = ST_IDLE;
                end
            end
        endcase
        nxt_d.sense = (nxt_d.state == ST_DETECT);
        nxt_d.main  = (nxt_d.state == ST_PROBE) || (nxt_d.state == ST_ON);
    end

    assign win_restart = (nxt_d.state != cur_q.state);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, sense: 1'b0, main: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sense_en = cur_q.sense;
    assign main_en  = cur_q.main;
    assign status   = cur_q.state;

    // R8: sense voltage and main switch are mutually exclusive.
    p_sense_main_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(sense_en && main_en));

    // R9: idle keeps both drives off.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status == ST_IDLE) |-> (!sense_en && !main_en));

    // R3: the main switch only closes straight out of a sense phase.
    p_main_after_detect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_en) |-> ($past(status) == ST_DETECT));

    // R5: ON is only reached from the probe window on a tick.
    p_on_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (status == ST_PROBE && !ms_tick) |=> (status != ST_ON));

    // R6: overcurrent while powered opens the switch on the next cycle.
    p_trip_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((status == ST_PROBE || status == ST_ON) && over_current)
            |=> (status == ST_IDLE && !main_en));

    // R7: loss of hold current in ON returns to idle.
    p_hold_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status == ST_ON && !hold_present) |=> (status == ST_IDLE));

    // R2: without a tick the timed states do not move.
    p_timed_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ms_tick && (status == ST_IDLE || status == ST_DETECT) ) |=> $stable(status));

endmodule

// File: tb/pwr_feed_detect_test.sv
module pwr_feed_detect_test;

    localparam int SENSE   = 5;
    localparam int PROBE   = 876;
    localparam int BACKOFF = 450;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic       sig_in_range = 1'b0;
    logic       pairs_cont = 1'b0;
    logic       all_pairs_req = 1'b0;
    logic       load_present = 1'b0;
    logic       hold_present = 1'b0;
    logic       over_current = 1'b0;
    logic       sense_en;
    logic       main_en;
    logic [1:0] status;

    int checks = 0;
    int errors = 0;
    int m_st = 0;
    int m_cnt = 0;
    bit done_flag = 1'b0;
    bit saw_detect = 1'b0;
    bit saw_probe = 1'b0;

    always #5 clk = ~clk;

    pwr_feed_detect #(
        .SENSE_MS   (SENSE),
        .PROBE_MS   (PROBE),
        .BACKOFF_MS (BACKOFF)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ms_tick       (ms_tick),
        .sig_in_range  (sig_in_range),
        .pairs_cont    (pairs_cont),
        .all_pairs_req (all_pairs_req),
        .load_present  (load_present),
        .hold_present  (hold_present),
        .over_current  (over_current),
        .sense_en      (sense_en),
        .main_en       (main_en),
        .status        (status)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model: compares the current cycle, then predicts the next.
    always @(negedge clk) begin
        chk(int'(status) == m_st, "R9 status", int'(status), m_st);
        chk(sense_en == (m_st == 1), "R3 sense_en", int'(sense_en), int'(m_st == 1));
        chk(main_en == (m_st >= 2), "R5 main_en", int'(main_en), int'(m_st >= 2));
        chk(!(sense_en && main_en), "R8 exclusive", int'(sense_en && main_en), 0);
        if (status == 2'd1) saw_detect = 1'b1;
        if (status == 2'd2) saw_probe = 1'b1;
        if (!rst_n) begin
            m_st = 0;
            m_cnt = 0;
        end else begin
            case (m_st)
                0: begin
                    if (ms_tick) begin
                        if (m_cnt == BACKOFF - 1) begin m_st = 1; m_cnt = 0; end
                        else m_cnt++;
                    end
                end
                1: begin
                    if (ms_tick) begin
                        if (m_cnt == SENSE - 1) begin
                            m_st = (sig_in_range && (!all_pairs_req || pairs_cont)) ? 2 : 0;
                            m_cnt = 0;
                        end else m_cnt++;
                    end
                end
                2: begin
                    if (over_current) begin m_st = 0; m_cnt = 0; end
                    else if (ms_tick) begin
                        if (m_cnt == PROBE - 1) begin m_st = load_present ? 3 : 0; m_cnt = 0; end
                        else m_cnt++;
                    end
                end
                default: begin
                    if (over_current || !hold_present) begin m_st = 0; m_cnt = 0; end
                end
            endcase
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            ms_tick = ($urandom_range(0, 3) != 0);
        end
    endtask

    task automatic wait_code(input int code, input int max_cyc);
        for (int i = 0; i < max_cyc; i++) begin
            @(posedge clk);
            #1;
            ms_tick = ($urandom_range(0, 3) != 0);
            if (int'(status) == code) break;
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(10 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(status == 2'd0 && !sense_en && !main_en, "R1 reset state", int'(status), 0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(status == 2'd0 && !sense_en && !main_en, "R1 first cycle", int'(status), 0);

        // R3: an invalid signature cycles IDLE/DETECT and never powers.
        step(1800);
        chk(saw_detect, "R2 detect reached", int'(saw_detect), 1);
        chk(!saw_probe, "R3 no power without signature", int'(saw_probe), 0);

        // R4: pairs_cont ignored when the pair check is off; R5 probe to ON.
        sig_in_range = 1'b1; load_present = 1'b1; hold_present = 1'b1;
        wait_code(3, 5000);
        chk(status == 2'd3, "R4 pairs ignored, R5 reached ON", int'(status), 3);
        step(60);
        chk(status == 2'd3 && main_en, "R7 ON persists", int'(status), 3);

        // R7: hold loss.
        hold_present = 1'b0;
        step(1);
        chk(status == 2'd0 && !main_en, "R7 hold loss to IDLE", int'(status), 0);
        hold_present = 1'b1;

        // R4: pair check enabled without continuity blocks power.
        all_pairs_req = 1'b1;
        step(2);
        saw_probe = 1'b0;
        step(3000);
        chk(!saw_probe, "R4 missing pairs blocks", int'(saw_probe), 0);
        pairs_cont = 1'b1;
        wait_code(2, 3000);
        chk(status == 2'd2 && main_en && !sense_en, "R4 pairs present powers", int'(status), 2);

        // R5: low current at window end returns to IDLE.
        load_present = 1'b0;
        wait_code(0, 3000);
        chk(status == 2'd0 && !main_en, "R5 low load to IDLE", int'(status), 0);

        // R5: load_present toggling mid-window is ignored; last tick decides.
        wait_code(2, 3000);
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk);
            #1;
            ms_tick = ($urandom_range(0, 3) != 0);
            if (m_st == 2 && m_cnt == PROBE - 1) load_present = 1'b1;
            else if (m_st == 2) load_present = $urandom_range(0, 1) != 0;
            if (status == 2'd3) break;
        end
        chk(status == 2'd3, "R5 mid-window load ignored", int'(status), 3);

        // R6: overcurrent in ON.
        step(20);
        over_current = 1'b1;
        step(1);
        over_current = 1'b0;
        chk(status == 2'd0 && !main_en, "R6 trip in ON", int'(status), 0);

        // R6: overcurrent mid-probe.
        wait_code(2, 3000);
        step(100);
        over_current = 1'b1;
        step(1);
        over_current = 1'b0;
        chk(status == 2'd0 && !main_en, "R6 trip in probe", int'(status), 0);

        // R6: trip on the same tick that completes the window with good load.
        load_present = 1'b1;
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            #1;
            if (m_st == 2 && m_cnt == PROBE - 1) begin
                ms_tick = 1'b1;
                over_current = 1'b1;
                break;
            end
            ms_tick = ($urandom_range(0, 3) != 0);
        end
        chk(status == 2'd2, "R6 collision setup", int'(status), 2);
        @(posedge clk);
        #1;
        over_current = 1'b0;
        ms_tick = 1'b0;
        chk(status == 2'd0 && !main_en, "R6 trip beats window end", int'(status), 0);

        // R2: no ticks, no progress.
        step(1);
        ms_tick = 1'b0;
        for (int i = 0; i < 700; i++) @(posedge clk);
        #1;
        chk(status == 2'd0, "R2 stalled without tick", int'(status), 0);

        step(10);
        finish_run();
    end

endmodule